// File: doc/BRIEF.md
# Zero-Detect Mute and Startup Sequencer

This block decides when a multichannel audio converter may play and when its external mute circuit must be engaged. It runs one clock domain, the converter's master clock, and is told once per audio frame that a fresh set of channel samples is valid. A four-state flow takes the converter from power-down through a wait for clocks and a ratio-detection hold into normal operation. Audio reaches the modulators only in normal operation.

Each channel keeps its own count of consecutive zero samples. The block raises the mute output when every channel has been silent for a long run. It drops that silence mute as soon as any channel carries a nonzero sample. Mute is also forced high whenever the flow is outside normal operation or the clock ratio is reported invalid. The flow state is driven out as a two-bit code.

Top module: `zmute_seq`

## Requirements
- R1: The silence mute becomes active after exactly ZERO_RUN (default 8192) consecutive strobed zero samples on every channel at once. It is not active after one sample fewer, and it stays active while zero samples continue, because the counters saturate.
- R2: A strobed sample that is nonzero on any single channel clears the silence mute at the clock edge that takes the sample.
- R3: The mute output is active high. It is high whenever the flow state is not normal operation, or ratio_ok is low, or the silence mute is active.
- R4: out_en is high in normal operation and low in every other state. The silence mute does not affect it.
- R5: seq_state encodes the flow as 0 = power-down, 1 = wait-for-clocks, 2 = ratio detection, 3 = normal operation. Releasing hold_rst moves power-down to wait-for-clocks. clk_ok high moves wait-for-clocks to ratio detection.
- R6: Ratio detection moves to normal operation on the START_FRAMES-th (default 2048) consecutive frame strobe with ratio_ok and mode_lock both high. A frame with either of them low restarts the count.
- R7: clk_ok low moves ratio detection or normal operation to wait-for-clocks at the next edge.
- R8: hold_rst high moves any state to power-down at the next edge.
- R9: A ratio_chg pulse, or ratio_ok low, in normal operation returns the flow to ratio detection. A ratio_chg pulse during ratio detection restarts the frame count.
- R10: Sample values presented while frame_stb is low are ignored by the zero-run counters.
- R11: While rst_n is low, seq_state is 0, mute is 1 and out_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| frame_stb | input | 1 | One-cycle strobe: samples hold a new frame |
| samples | input | NUM_CH*SAMPLE_W | Packed channel samples, channel 0 in the low bits |
| hold_rst | input | 1 | Converter reset request, active high |
| clk_ok | input | 1 | Master and frame clocks are both present |
| ratio_ok | input | 1 | Measured clock ratio is a supported one |
| ratio_chg | input | 1 | One-cycle pulse: clock ratio has changed |
| mode_lock | input | 1 | Speed mode has been locked |
| mute | output | 1 | External mute control, active high |
| out_en | output | 1 | Enables audio toward the modulators |
| seq_state | output | 2 | Flow state code |

## Verification
The silence detector is tried with all channels zero, which finds the exact run length and shows saturation. It is also tried with a single nonzero channel among zeros, which shows that every channel must agree, and with a one-sample nonzero glitch, which shows the immediate release. A run interrupted by unstrobed nonzero values shows that only strobed frames count. The flow table walks every legal transition and shows that frames without ratio validity or mode lock do not advance the startup count. It also restarts that count with a ratio-change pulse in mid-count, which separates a restart from a pause.

// File: rtl/zmute_seq_pkg.sv
package zmute_seq_pkg;
   typedef enum logic [1:0] {
      ST_OFF    = 2'd0,
      ST_WAIT   = 2'd1,
      ST_DETECT = 2'd2,
      ST_RUN    = 2'd3
   } seq_st_e;
endpackage

// File: rtl/zrun_cnt.sv
// Counts consecutive strobed zero samples of one channel, saturating at LIMIT.
module zrun_cnt #(
   parameter int SAMPLE_W = 24,
   parameter int LIMIT    = 8192
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stb,
   input  logic [SAMPLE_W-1:0] smp,
   output logic                sat
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (stb) begin
         if (smp != '0)
            run_q <= '0;
         else if (run_q != TOP)
            run_q <= run_q + 1'b1;
      end
   end

   assign sat = (run_q == TOP);
endmodule

// File: rtl/seq_fsm.sv
// Startup flow: power-down, wait for clocks, ratio detection with frame delay, run.
module seq_fsm
   import zmute_seq_pkg::*;
#(
   parameter int START_FRAMES = 2048
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    frame_stb,
   input  logic    hold_rst,
   input  logic    clk_ok,
   input  logic    ratio_ok,
   input  logic    ratio_chg,
   input  logic    mode_lock,
   output seq_st_e st
);
   localparam int FW = $clog2(START_FRAMES + 1);
   localparam logic [FW-1:0] LAST = FW'(START_FRAMES - 1);

   seq_st_e       st_q, st_d;
   logic [FW-1:0] frm_q;
   logic          qual;
   logic          count_en;

   assign qual     = ratio_ok && mode_lock;
   assign count_en = (st_q == ST_DETECT) && clk_ok && qual && !ratio_chg;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_OFF:    if (!hold_rst) st_d = ST_WAIT;
         ST_WAIT:   if (clk_ok) st_d = ST_DETECT;
         ST_DETECT: begin
            if (!clk_ok)
               st_d = ST_WAIT;
            else if (count_en && frame_stb && frm_q == LAST)
               st_d = ST_RUN;
         end
         ST_RUN: begin
            if (!clk_ok)
               st_d = ST_WAIT;
            else if (ratio_chg || !ratio_ok)
               st_d = ST_DETECT;
         end
         default:   st_d = ST_OFF;
      endcase
      if (hold_rst)
         st_d = ST_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= ST_OFF;
      else
         st_q <= st_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frm_q <= '0;
      else if (!count_en)
         frm_q <= '0;
      else if (frame_stb)
         frm_q <= frm_q + 1'b1;
   end

   assign st = st_q;
endmodule

// File: rtl/zmute_seq.sv
module zmute_seq
   import zmute_seq_pkg::*;
#(
   parameter int NUM_CH       = 6,
   parameter int SAMPLE_W     = 24,
   parameter int ZERO_RUN     = 8192,
   parameter int START_FRAMES = 2048,
   parameter bit MUTE_REG     = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_stb,
   input  logic [NUM_CH*SAMPLE_W-1:0] samples,
   input  logic                       hold_rst,
   input  logic                       clk_ok,
   input  logic                       ratio_ok,
   input  logic                       ratio_chg,
   input  logic                       mode_lock,
   output logic                       mute,
   output logic                       out_en,
   output logic [1:0]                 seq_state
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("zmute_seq: NUM_CH must be at least 1");
   end
   if (SAMPLE_W < 1) begin : g_bad_w
      $error("zmute_seq: SAMPLE_W must be at least 1");
   end
   if (ZERO_RUN < 2) begin : g_bad_run
      $error("zmute_seq: ZERO_RUN must be at least 2");
   end
   if (START_FRAMES < 1) begin : g_bad_start
      $error("zmute_seq: START_FRAMES must be at least 1");
   end

   logic [NUM_CH-1:0] ch_sat;
   logic              all_sil;
   logic              mute_d;
   seq_st_e           st;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      zrun_cnt #(
         .SAMPLE_W(SAMPLE_W),
         .LIMIT   (ZERO_RUN)
      ) u_run (
         .clk  (clk),
         .rst_n(rst_n),
         .stb  (frame_stb),
         .smp  (samples[c*SAMPLE_W +: SAMPLE_W]),
         .sat  (ch_sat[c])
      );
   end

   assign all_sil = &ch_sat;

   seq_fsm #(
      .START_FRAMES(START_FRAMES)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .hold_rst (hold_rst),
      .clk_ok   (clk_ok),
      .ratio_ok (ratio_ok),
      .ratio_chg(ratio_chg),
      .mode_lock(mode_lock),
      .st       (st)
   );

   assign mute_d = (st != ST_RUN) || !ratio_ok || all_sil;

   if (MUTE_REG) begin : g_mute_ff
      logic mute_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mute_q <= 1'b1;
         else
            mute_q <= mute_d;
      end
      assign mute = mute_q;
   end else begin : g_mute_comb
      assign mute = mute_d;
   end

   assign out_en    = (st == ST_RUN);
   assign seq_state = st;
endmodule

// File: rtl/zmute_seq_chk.sv
module zmute_seq_chk
   import zmute_seq_pkg::*;
#(
   parameter int NUM_CH   = 6,
   parameter int SAMPLE_W = 24,
   parameter bit MUTE_REG = 1'b0
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       frame_stb,
   input logic [NUM_CH*SAMPLE_W-1:0] samples,
   input logic                       hold_rst,
   input logic                       clk_ok,
   input logic                       ratio_ok,
   input logic                       ratio_chg,
   input logic                       mode_lock,
   input logic                       mute,
   input logic                       out_en,
   input logic [1:0]                 seq_state,
   input logic                       sil
);
   a_r8_hold_to_off: assert property (@(posedge clk) disable iff (!rst_n)
      hold_rst |=> seq_state == ST_OFF);

   a_r5_off_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_state == ST_OFF && !hold_rst) |=> seq_state == ST_WAIT);

   a_r7_clk_loss: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_rst && !clk_ok && (seq_state == ST_DETECT || seq_state == ST_RUN))
      |=> seq_state == ST_WAIT);

   a_r9_ratio_back: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_rst && clk_ok && seq_state == ST_RUN && (ratio_chg || !ratio_ok))
      |=> seq_state == ST_DETECT);

   a_r6_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_state == ST_RUN) |-> $past(seq_state) == ST_DETECT);

   a_r4_enable_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en) |-> $past(clk_ok && ratio_ok && mode_lock && frame_stb));

   a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && samples != '0) |=> !sil);

   if (MUTE_REG) begin : g_chk_ff
      a_r3_mute_forced: assert property (@(posedge clk) disable iff (!rst_n)
         (seq_state != ST_RUN || !ratio_ok || sil) |=> mute);
   end else begin : g_chk_comb
      a_r3_mute_forced: assert property (@(posedge clk) disable iff (!rst_n)
         (seq_state != ST_RUN || !ratio_ok || sil) |-> mute);
   end
endmodule

bind zmute_seq zmute_seq_chk #(
   .NUM_CH  (NUM_CH),
   .SAMPLE_W(SAMPLE_W),
   .MUTE_REG(MUTE_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_stb(frame_stb),
   .samples  (samples),
   .hold_rst (hold_rst),
   .clk_ok   (clk_ok),
   .ratio_ok (ratio_ok),
   .ratio_chg(ratio_chg),
   .mode_lock(mode_lock),
   .mute     (mute),
   .out_en   (out_en),
   .seq_state(seq_state),
   .sil      (all_sil)
);

// File: tb/zmute_seq_tb.sv
module zmute_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 6;
   localparam int SW    = 24;
   localparam int ZRUN  = 16;
   localparam int START = 12;
   localparam int NSTEP = 19;

   // rq[20:17] hold[16] clk[15] rok[14] chg[13] lock[12] n[11:4] st[3:2] mute[1] en[0]
   localparam logic [20:0] TBL [NSTEP] = '{
      {4'd8, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'd2,  2'd0, 1'b1, 1'b0},
      {4'd5, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd2,  2'd1, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b0,1'b0,1'b1, 8'd3,  2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd11, 2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd1,  2'd3, 1'b0, 1'b1},
      {4'd9, 1'b0,1'b1,1'b1,1'b1,1'b1, 8'd1,  2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd12, 2'd3, 1'b0, 1'b1},
      {4'd7, 1'b0,1'b0,1'b1,1'b0,1'b1, 8'd1,  2'd1, 1'b1, 1'b0},
      {4'd5, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd1,  2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b0, 8'd20, 2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd12, 2'd3, 1'b0, 1'b1},
      {4'd3, 1'b0,1'b1,1'b0,1'b0,1'b1, 8'd1,  2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd12, 2'd3, 1'b0, 1'b1},
      {4'd8, 1'b1,1'b1,1'b1,1'b0,1'b1, 8'd1,  2'd0, 1'b1, 1'b0},
      {4'd5, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd2,  2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd6,  2'd2, 1'b1, 1'b0},
      {4'd9, 1'b0,1'b1,1'b1,1'b1,1'b1, 8'd1,  2'd2, 1'b1, 1'b0},
      {4'd6, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd11, 2'd2, 1'b1, 1'b0},
      {4'd9, 1'b0,1'b1,1'b1,1'b0,1'b1, 8'd1,  2'd3, 1'b0, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              frame_stb;
   logic [NCH*SW-1:0] samples;
   logic              hold_rst, clk_ok, ratio_ok, ratio_chg, mode_lock;
   logic              mute, out_en;
   logic [1:0]        seq_state;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   zmute_seq #(
      .NUM_CH(NCH), .SAMPLE_W(SW), .ZERO_RUN(ZRUN), .START_FRAMES(START), .MUTE_REG(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .samples(samples),
      .hold_rst(hold_rst), .clk_ok(clk_ok), .ratio_ok(ratio_ok),
      .ratio_chg(ratio_chg), .mode_lock(mode_lock),
      .mute(mute), .out_en(out_en), .seq_state(seq_state)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_all(input logic [SW-1:0] v);
      for (int c = 0; c < NCH; c++) samples[c*SW +: SW] = v;
   endtask

   task automatic strobes(input int n);
      frame_stb = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 20000);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; frame_stb = 1'b0; hold_rst = 1'b1; clk_ok = 1'b0;
      ratio_ok = 1'b0; ratio_chg = 1'b0; mode_lock = 1'b0;
      set_all(24'h000123);
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11", "reset state", seq_state, 0);
      check("R11", "reset mute", mute, 1);
      check("R11", "reset out_en", out_en, 0);
      rst_n = 1'b1;

      // flow table, nonzero samples so silence never engages
      for (int i = 0; i < NSTEP; i++) begin
         string rq;
         rq = $sformatf("R%0d step%0d", TBL[i][20:17], i);
         hold_rst  = TBL[i][16];
         clk_ok    = TBL[i][15];
         ratio_ok  = TBL[i][14];
         ratio_chg = TBL[i][13];
         mode_lock = TBL[i][12];
         strobes(int'(TBL[i][11:4]));
         check(rq, "state", seq_state, int'(TBL[i][3:2]));
         check({rq, " R3"}, "mute", mute, int'(TBL[i][1]));
         check({rq, " R4"}, "out_en", out_en, int'(TBL[i][0]));
      end
      ratio_chg = 1'b0;

      // R1: one short of the run, then exactly the run
      set_all('0);
      strobes(ZRUN - 1);
      check("R1", "mute one short", mute, 0);
      strobes(1);
      check("R1", "mute at run length", mute, 1);
      check("R4", "out_en under silence", out_en, 1);
      strobes(20);
      check("R1", "mute saturated", mute, 1);

      // R2: single nonzero channel releases at once
      samples[3*SW +: SW] = 24'h000001;
      strobes(1);
      check("R2", "release on one sample", mute, 0);

      // R10: unstrobed nonzero values do not break a run
      set_all('0);
      strobes(10);
      frame_stb = 1'b0;
      set_all(24'hFFFFFF);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R10", "no strobe mute", mute, 0);
      set_all('0);
      strobes(ZRUN - 10);
      check("R10", "run survives unstrobed data", mute, 1);

      // R1: one channel active blocks silence mute
      samples[5*SW +: SW] = 24'h800000;
      strobes(3 * ZRUN);
      check("R1", "one live channel", mute, 0);

      // R11: block reset from running state
      rst_n = 1'b0;
      @(negedge clk);
      check("R11", "reset again state", seq_state, 0);
      check("R11", "reset again mute", mute, 1);
      rst_n = 1'b1;
      hold_rst = 1'b0;
      strobes(1);
      check("R5", "off to wait", seq_state, 1);

      finish_run();
   end
endmodule